// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block holds one 32-bit control and status word that tells software why the machine last came out of reset. Software can also write the word to ask for a new system reset. Five cause flags sit in the top bits of the word. Some of those flags clear when a one is written to them. Others can only be set by a write, and setting them also raises a single-cycle reset request towards the system reset logic.

The block also records whether the next system reset should count as a power-on reset. A power-up reset arms that record. The first system reset after that consumes it and loads the word with only the power-on flag. Later system resets leave the word alone. A soft power-on write arms the record again, so the reset it provokes reports power-on once more. The word sits in the upper half of an 8-byte slot. The lower half reads as zero and ignores writes.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The cause flags use these bit positions: bit 31 power-on, bit 30 soft power-on request, bit 29 soft external reset request, bit 28 button power-on, bit 27 button external reset. Bits 26:0 always read as zero.
- R2: Write data bits 26:0 are dropped before use and never reach the stored word.
- R3: Writing a 1 to bit 31, 28 or 27 clears that flag. Writing a 0 there leaves the flag unchanged.
- R4: Writing a 1 to bit 30 or 29 sets that flag. Writing a 0 there never clears it.
- R5: A write with bit 30 set drives `rst_req` high for exactly the one cycle that follows the write edge.
- R6: A write with bit 29 set and bit 30 clear also gives that one-cycle pulse. A write with both bits set gives a single pulse, with the bit 30 behaviour (re-arming) applied.
- R7: While `por_n` is low, the stored word is zero, `rst_req` is low and the power-on record is armed. The first `sys_rst` cycle after that loads the word with 0x8000_0000.
- R8: A `sys_rst` cycle while the power-on record is not armed leaves the word unchanged.
- R9: A write with bit 30 set re-arms the power-on record, so the next `sys_rst` loads 0x8000_0000 again. A write with only bit 29 set does not re-arm it.
- R10: An access with `acc_addr` (address bit 2) low reads zero, and a write there changes nothing and gives no pulse.
- R11: When `sys_rst` and a write fall in the same cycle, the reset wins. The write is discarded completely: it changes no flag, gives no pulse and does not re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| sys_rst | input | 1 | System reset event, synchronous, active high |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | Access is a write when high |
| acc_addr | input | 1 | Address bit 2: selects the upper word of the slot |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data (combinational from `acc_addr`) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A system reset and a register write can land on the same clock edge. The bench provokes this by asserting `sys_rst` together with a soft power-on write while the power-on record is already consumed. It then expects three things: no pulse on the following cycle, an unchanged word, and an unchanged word again after one more reset, which proves the discarded write did not re-arm the record. Every cycle the scoreboard also compares `rst_req` with its expected level, so both a pulse that is missing and a pulse that lasts too long are caught.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int REG_W        = 32;
   localparam int POR_BIT      = 31;
   localparam int SOFT_PWR_BIT = 30;
   localparam int SOFT_EXT_BIT = 29;
   localparam int SLOT_SEL_BIT = 2;
   localparam logic [REG_W-1:0] KEEP_MASK = 32'hF800_0000;
   localparam logic [REG_W-1:0] CLR_MASK  = 32'h9800_0000;
   localparam logic [REG_W-1:0] SET_MASK  = 32'h6000_0000;

   typedef struct packed {
      logic             hit;
      logic [REG_W-1:0] data;
      logic             req;
      logic             rearm;
   } wr_cmd_t;
endpackage

// File: rtl/rstc_wr_decode.sv
module rstc_wr_decode
   import rstc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic              acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              sys_rst,
   output wr_cmd_t           cmd
);
   logic [DATA_W-1:0] masked;

   always_comb begin
      masked    = acc_wdata & KEEP_MASK;
      cmd.hit   = acc_en & acc_we & acc_addr & ~sys_rst;
      cmd.data  = masked;
      cmd.req   = 1'b0;
      cmd.rearm = 1'b0;
      if (cmd.hit) begin
         if (masked[SOFT_PWR_BIT]) begin
            cmd.req   = 1'b1;
            cmd.rearm = 1'b1;
         end else if (masked[SOFT_EXT_BIT]) begin
            cmd.req   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rstc_status_reg.sv
module rstc_status_reg
   import rstc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst,
   input  wr_cmd_t           cmd,
   output logic [DATA_W-1:0] stat_q,
   output logic              armed_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 armed_q <= 1'b1;
      else if (sys_rst)           armed_q <= 1'b0;
      else if (cmd.rearm)         armed_q <= 1'b1;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (!KEEP_MASK[i]) begin : g_unused
         assign stat_q[i] = 1'b0;
      end else begin : g_flag
         logic b_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               b_q <= 1'b0;
            end else if (sys_rst) begin
               if (armed_q) b_q <= (i == POR_BIT);
            end else if (cmd.hit) begin
               if (CLR_MASK[i] && cmd.data[i])      b_q <= 1'b0;
               else if (SET_MASK[i] && cmd.data[i]) b_q <= 1'b1;
            end
         end
         assign stat_q[i] = b_q;
      end
   end
endmodule

// File: rtl/rstc_req_pulse.sv
module rstc_req_pulse (
   input  logic clk,
   input  logic por_n,
   input  logic req_in,
   output logic req_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) req_q <= 1'b0;
      else        req_q <= req_in;
   end
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
   import rstc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic              acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              rst_req
);
   if (DATA_W != REG_W) begin : g_bad_width
      $error("rst_cause_ctrl: DATA_W must equal %0d", REG_W);
   end

   wr_cmd_t           cmd;
   logic [DATA_W-1:0] stat_q;
   logic              armed_q;

   rstc_wr_decode #(.DATA_W(DATA_W)) dec_i (
      .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .sys_rst(sys_rst), .cmd(cmd)
   );

   rstc_status_reg #(.DATA_W(DATA_W)) reg_i (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .cmd(cmd),
      .stat_q(stat_q), .armed_q(armed_q)
   );

   rstc_req_pulse pulse_i (
      .clk(clk), .por_n(por_n), .req_in(cmd.req), .req_q(rst_req)
   );

   assign acc_rdata = acc_addr ? stat_q : '0;
endmodule

// File: rtl/rst_cause_ctrl_chk.sv
module rst_cause_ctrl_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              por_n,
   input logic              sys_rst,
   input logic              acc_en,
   input logic              acc_we,
   input logic              acc_addr,
   input logic [DATA_W-1:0] acc_wdata,
   input logic [DATA_W-1:0] acc_rdata,
   input logic              rst_req,
   input logic [DATA_W-1:0] stat_q
);
   logic soft_wr;
   assign soft_wr = acc_en & acc_we & acc_addr & ~sys_rst & (acc_wdata[30] | acc_wdata[29]);

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      acc_rdata[26:0] == '0); // R1
   AST_LOWER_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      !acc_addr |-> acc_rdata == '0); // R10
   AST_CLR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      (acc_en & acc_we & acc_addr & ~sys_rst & ~acc_wdata[31]) |=> stat_q[31] == $past(stat_q[31])); // R3
   AST_SET_NOT_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
      (acc_en & acc_we & acc_addr & ~sys_rst) |=> (stat_q[30:29] & $past(stat_q[30:29])) == $past(stat_q[30:29])); // R4
   AST_REQ_AFTER_SOFT: assert property (@(posedge clk) disable iff (!por_n)
      soft_wr |=> rst_req); // R5
   AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |-> $past(soft_wr)); // R11
   AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst |=> (stat_q == 32'h8000_0000 || stat_q == $past(stat_q))); // R8
endmodule

bind rst_cause_ctrl rst_cause_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .acc_en(acc_en),
   .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
   .acc_rdata(acc_rdata), .rst_req(rst_req), .stat_q(stat_q)
);

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          sys_rst = 1'b0;
   logic          acc_en = 1'b0;
   logic          acc_we = 1'b0;
   logic          acc_addr = 1'b0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] acc_rdata;
   logic          rst_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_ctrl #(.DATA_W(DW)) dut_i (
      .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .acc_en(acc_en),
      .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .rst_req(rst_req)
   );

   typedef struct {
      int            due;
      bit            is_req;
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 0;

   // Monitor: samples at the falling edge, pops items that are due
   always @(negedge clk) begin
      cyc++;
      while (sb.size() > 0 && sb[0].due == cyc) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (it.is_req) begin
            if (rst_req !== it.exp[0]) begin
               n_fail++;
               $display("FAIL %s: rst_req=%0b expected %0b (cycle %0d)", it.tag, rst_req, it.exp[0], cyc);
            end
         end else if (acc_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%08h expected %08h (cycle %0d)", it.tag, acc_rdata, it.exp, cyc);
         end
      end
   end

   task automatic op(input logic en, input logic we, input logic a, input logic [DW-1:0] wd,
                     input logic srst, input logic exp_req, input bit chk_rd,
                     input logic [DW-1:0] exp_rd, input string tag);
      item_t it;
      @(negedge clk);
      #1;
      acc_en = en; acc_we = we; acc_addr = a; acc_wdata = wd; sys_rst = srst;
      it.due = cyc + 1; it.is_req = 1'b1; it.exp = {31'd0, exp_req}; it.tag = tag;
      sb.push_back(it);
      if (chk_rd) begin
         it.is_req = 1'b0; it.exp = exp_rd;
         sb.push_back(it);
      end
   endtask

   task automatic wr(input logic a, input logic [DW-1:0] d, input logic pulse, input string tag);
      op(1'b1, 1'b1, a, d, 1'b0, pulse, 1'b0, '0, tag);
   endtask
   task automatic rd(input logic a, input logic [DW-1:0] e, input string tag);
      op(1'b1, 1'b0, a, '0, 1'b0, 1'b0, 1'b1, e, tag);
   endtask
   task automatic srst(input string tag);
      op(1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, '0, tag);
   endtask
   task automatic idle(input string tag);
      op(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 por_n = 1'b1;
      rd(1'b1, 32'h0000_0000, "R7 reset state");
      rd(1'b0, 32'h0000_0000, "R10 lower word");
      srst("R7 first system reset");
      rd(1'b1, 32'h8000_0000, "R7 power-on load");
      wr(1'b1, 32'h0000_0000, 1'b0, "R3 zero write");
      rd(1'b1, 32'h8000_0000, "R3 zero keeps bit31");
      wr(1'b1, 32'h2000_0000, 1'b1, "R6 ext request pulse");
      rd(1'b1, 32'hA000_0000, "R4 bit29 set");
      wr(1'b1, 32'h07FF_FFFF, 1'b0, "R2 low bits write");
      rd(1'b1, 32'hA000_0000, "R1/R2 low bits dropped");
      wr(1'b1, 32'h8000_0000, 1'b0, "R3 clear bit31");
      rd(1'b1, 32'h2000_0000, "R3 bit31 cleared");
      wr(1'b0, 32'h6000_0000, 1'b0, "R10 lower write");
      rd(1'b1, 32'h2000_0000, "R10 lower write ignored");
      srst("R9 reset without rearm");
      rd(1'b1, 32'h2000_0000, "R8/R9 word kept");
      wr(1'b1, 32'h4000_0000, 1'b1, "R5 soft power-on pulse");
      rd(1'b1, 32'h6000_0000, "R4 bit30 set");
      wr(1'b1, 32'h0000_0000, 1'b0, "R4 zero write");
      rd(1'b1, 32'h6000_0000, "R4 zero keeps set bits");
      srst("R9 rearmed reset");
      rd(1'b1, 32'h8000_0000, "R9 power-on again");
      srst("R8 second reset");
      rd(1'b1, 32'h8000_0000, "R8 word kept");
      wr(1'b1, 32'h9800_0000, 1'b0, "R3 clear mask");
      rd(1'b1, 32'h0000_0000, "R3 all cleared");
      wr(1'b1, 32'h6000_0000, 1'b1, "R6 both bits one pulse");
      wr(1'b1, 32'h2000_0000, 1'b1, "R6 back-to-back pulse");
      rd(1'b1, 32'h6000_0000, "R6 both set");
      srst("R6 rearmed by both");
      rd(1'b1, 32'h8000_0000, "R6 power-on reported");
      wr(1'b1, 32'h8000_0000, 1'b0, "R3 clear bit31 again");
      op(1'b1, 1'b1, 1'b1, 32'h4000_0000, 1'b1, 1'b0, 1'b0, '0, "R11 collision no pulse");
      rd(1'b1, 32'h0000_0000, "R11 write discarded");
      srst("R11 no rearm");
      rd(1'b1, 32'h0000_0000, "R11 rearm discarded");
      idle("R5 pulse ends");
      idle("R5 idle");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule